// File: doc/BRIEF.md
# Ping-Pong Coefficient Profile Buffer

This block holds channel frequency-response profiles for a streaming channel emulator. It has two profile banks. A loader takes one 32-bit complex coefficient per cycle from the host side and fills one bank. The processing lanes read coefficients from the other bank at the same time. Each coefficient word carries a one-bit profile tag. The tag travels with the word into the bank and comes back out with it on the read side.

A periodic refresh strobe exchanges the two roles. The exchange only happens when the bank being filled already holds a complete profile. If the strobe finds that bank incomplete, the exchange is skipped and an underrun indication is raised. Each lane binds itself to a bank at the start of each segment. A segment starts with a read of address 0. As a result, a lane always finishes a segment on the profile it began with, even when an exchange happens in the middle of that segment. The loader will not write into a bank that any lane is still bound to.

Top module: `coef_pingpong_buf`

## Requirements
- R1: After synchronous reset, `active_valid`, `underrun` and every `lane_rd_vld` bit are 0. Bank A is the read bank and bank B is the fill bank.
- R2: A host word is stored with real part = bits [31:16], imaginary part = bits [15:0] and its tag. A lane read issued in one cycle raises that lane's `lane_rd_vld` in the next cycle and returns the stored real part, imaginary part and tag in that same cycle.
- R3: Accepted host words fill the fill bank at consecutive addresses starting from 0. The bank becomes complete after PROF_LEN accepted words. Host words that arrive while the fill bank is complete are ignored.
- R4: If the fill pointer is not 0 and a host word arrives whose tag differs from the tag of the word at address 0, that word is written to address 0 and the fill restarts from there.
- R5: A refresh strobe while the fill bank is complete exchanges the banks in the next cycle. `active_valid` goes to 1, `underrun` goes to 0, and the fill of the new fill bank starts again from address 0.
- R6: A refresh strobe while the fill bank is incomplete leaves the banks unchanged and sets `underrun`. `underrun` stays at 1 until the next successful exchange.
- R7: A lane binds to the current read bank when it reads address 0. Its other reads come from the bank it is bound to, so a segment in progress keeps its old profile across an exchange.
- R8: Host words are ignored and the fill pointer holds while any lane is still bound to the fill bank.
- R9: Each lane has its own address and bank selection, and lanes can read different addresses in the same cycle.
- R10: A bank that was only partly filled when a refresh strobe arrived keeps its partial fill. It becomes eligible for an exchange only after it has received all PROF_LEN words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host coefficient word present |
| host_word | input | 32 | Coefficient: real [31:16], imaginary [15:0] |
| host_tag | input | 1 | Profile tag of the host word |
| refresh | input | 1 | Refresh strobe; each high cycle is one strobe |
| active_valid | output | 1 | A complete profile has been brought into use |
| underrun | output | 1 | The last strobe found the fill bank incomplete |
| lane_rd_en | input | NUM_LANES | Per-lane read request |
| lane_rd_addr | input | NUM_LANES*AW | Per-lane coefficient index; lane l uses bits [l*AW +: AW] |
| lane_rd_vld | output | NUM_LANES | Per-lane read data valid |
| lane_rd_re | output | NUM_LANES*16 | Per-lane real part |
| lane_rd_im | output | NUM_LANES*16 | Per-lane imaginary part |
| lane_rd_tag | output | NUM_LANES | Per-lane tag of the returned word |

## Verification
Directed phases check each behaviour on its own:
- A strobe on an empty fill bank.
- A short fill with one tag followed by a full fill with the other tag, which separates a restart from a plain continuation.
- Writes during a lane hold. Any of these that were accepted would shift every later address.
- An exchange in the middle of a segment, which separates per-segment binding from immediate switching.
- Lanes reading opposite address orders, which exposes shared address decoding.

After that, a long pseudo-random phase mixes host writes, tag changes, strobes and lane segments. A behavioural model predicts every output on every clock.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;

    localparam int PART_W = 16;
    localparam int WORD_W = 2 * PART_W;
    localparam int COEF_W = WORD_W + 1;

    typedef struct packed {
        logic              tag;
        logic [PART_W-1:0] re;
        logic [PART_W-1:0] im;
    } coef_t;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    function automatic bank_e other_bank(input bank_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction

    function automatic coef_t make_coef(input logic [WORD_W-1:0] w, input logic t);
        coef_t c;
        c.tag = t;
        c.re  = w[WORD_W-1:PART_W];
        c.im  = w[PART_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/ppbuf_bank_ram.sv
module ppbuf_bank_ram
    import ppbuf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = 5,
    parameter int NRD   = 2
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [AW-1:0]                waddr,
    input  coef_t                        wdata,
    input  logic [NRD-1:0][AW-1:0]       raddr,
    output logic [NRD-1:0][COEF_W-1:0]   rdata
);

    coef_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        always_comb begin
            if (32'(raddr[r]) < DEPTH) begin
                rdata[r] = mem[raddr[r]];
            end else begin
                rdata[r] = '0;
            end
        end
    end

endmodule

// File: rtl/ppbuf_loader.sv
module ppbuf_loader
    import ppbuf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    input  logic [WORD_W-1:0] host_word,
    input  logic              host_tag,
    input  logic              swap,
    input  logic              held,
    output logic              ram_we,
    output logic [AW-1:0]     ram_waddr,
    output coef_t             ram_wdata,
    output logic              fill_done
);

    localparam int CW = AW + 1;

    logic [CW-1:0] fill_cnt;
    logic          head_tag;
    logic          accept;
    logic          restart;

    assign fill_done = (32'(fill_cnt) == DEPTH);
    assign accept    = host_valid && !fill_done && !held;
    assign restart   = (fill_cnt != '0) && (host_tag != head_tag);
    assign ram_waddr = restart ? '0 : fill_cnt[AW-1:0];
    assign ram_we    = accept;
    assign ram_wdata = make_coef(host_word, host_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt <= '0;
            head_tag <= 1'b0;
        end else if (swap) begin
            fill_cnt <= '0;
        end else if (accept) begin
            fill_cnt <= {1'b0, ram_waddr} + CW'(1);
            if (ram_waddr == '0) begin
                head_tag <= host_tag;
            end
        end
    end

    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(fill_cnt) <= DEPTH);

    // R3
    full_ignores_chk: assert property (@(posedge clk) disable iff (rst)
        fill_done && !swap |=> $stable(fill_cnt));

    // R8
    held_ignores_chk: assert property (@(posedge clk) disable iff (rst)
        held && !swap |=> $stable(fill_cnt));

endmodule

// File: rtl/ppbuf_swap_ctrl.sv
module ppbuf_swap_ctrl
    import ppbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  refresh,
    input  logic  fill_done,
    output logic  swap,
    output bank_e active_bank,
    output logic  underrun,
    output logic  active_valid
);

    assign swap = refresh && fill_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_bank  <= BANK_A;
            underrun     <= 1'b0;
            active_valid <= 1'b0;
        end else if (swap) begin
            active_bank  <= other_bank(active_bank);
            underrun     <= 1'b0;
            active_valid <= 1'b1;
        end else if (refresh) begin
            underrun     <= 1'b1;
        end
    end

    // R5
    swap_taken_chk: assert property (@(posedge clk) disable iff (rst)
        refresh && fill_done |=> (active_bank != $past(active_bank)) && !underrun);

    // R6
    swap_skip_chk: assert property (@(posedge clk) disable iff (rst)
        refresh && !fill_done |=> $stable(active_bank) && underrun);

    // R5
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active_valid) |-> $past(refresh) && $past(fill_done));

endmodule

// File: rtl/ppbuf_lane.sv
module ppbuf_lane
    import ppbuf_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  bank_e         active_bank,
    input  coef_t         word_a,
    input  coef_t         word_b,
    output logic          rd_vld,
    output coef_t         rd_word,
    output bank_e         seg_bank
);

    logic  seg_start;
    bank_e pick;

    assign seg_start = rd_en && (rd_addr == '0);
    assign pick      = seg_start ? active_bank : seg_bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_bank <= BANK_A;
            rd_vld   <= 1'b0;
        end else begin
            rd_vld <= rd_en;
            if (seg_start) begin
                seg_bank <= active_bank;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_word <= (pick == BANK_A) ? word_a : word_b;
        end
    end

    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_vld);

    // R2
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_vld && $stable(rd_word));

    // R7
    seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !seg_start |=> $stable(seg_bank));

endmodule

// File: rtl/coef_pingpong_buf.sv
module coef_pingpong_buf
    import ppbuf_pkg::*;
#(
    parameter int PROF_LEN  = 32,
    parameter int NUM_LANES = 2,
    parameter int AW        = $clog2(PROF_LEN)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        host_valid,
    input  logic [WORD_W-1:0]           host_word,
    input  logic                        host_tag,
    input  logic                        refresh,
    output logic                        active_valid,
    output logic                        underrun,
    input  logic [NUM_LANES-1:0]        lane_rd_en,
    input  logic [NUM_LANES*AW-1:0]     lane_rd_addr,
    output logic [NUM_LANES-1:0]        lane_rd_vld,
    output logic [NUM_LANES*PART_W-1:0] lane_rd_re,
    output logic [NUM_LANES*PART_W-1:0] lane_rd_im,
    output logic [NUM_LANES-1:0]        lane_rd_tag
);

    localparam int NBANK = 2;

    logic                                      swap;
    logic                                      fill_done;
    logic                                      held;
    bank_e                                     active_bank;
    bank_e                                     fill_bank;
    logic                                      ld_we;
    logic [AW-1:0]                             ld_waddr;
    coef_t                                     ld_wdata;
    logic [NUM_LANES-1:0][AW-1:0]              raddr_v;
    logic [NBANK-1:0][NUM_LANES-1:0][COEF_W-1:0] bank_rd;
    bank_e                                     lane_bank [NUM_LANES];
    coef_t                                     lane_word [NUM_LANES];

    assign raddr_v   = lane_rd_addr;
    assign fill_bank = other_bank(active_bank);

    always_comb begin
        held = 1'b0;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (lane_bank[l] == fill_bank) begin
                held = 1'b1;
            end
        end
    end

    ppbuf_swap_ctrl u_swap (
        .clk          (clk),
        .rst          (rst),
        .refresh      (refresh),
        .fill_done    (fill_done),
        .swap         (swap),
        .active_bank  (active_bank),
        .underrun     (underrun),
        .active_valid (active_valid)
    );

    ppbuf_loader #(
        .DEPTH (PROF_LEN),
        .AW    (AW)
    ) u_loader (
        .clk        (clk),
        .rst        (rst),
        .host_valid (host_valid),
        .host_word  (host_word),
        .host_tag   (host_tag),
        .swap       (swap),
        .held       (held),
        .ram_we     (ld_we),
        .ram_waddr  (ld_waddr),
        .ram_wdata  (ld_wdata),
        .fill_done  (fill_done)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic bank_we;
        assign bank_we = ld_we && (fill_bank == bank_e'(b));

        ppbuf_bank_ram #(
            .DEPTH (PROF_LEN),
            .AW    (AW),
            .NRD   (NUM_LANES)
        ) u_ram (
            .clk   (clk),
            .we    (bank_we),
            .waddr (ld_waddr),
            .wdata (ld_wdata),
            .raddr (raddr_v),
            .rdata (bank_rd[b])
        );
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        ppbuf_lane #(
            .AW (AW)
        ) u_lane (
            .clk         (clk),
            .rst         (rst),
            .rd_en       (lane_rd_en[l]),
            .rd_addr     (raddr_v[l]),
            .active_bank (active_bank),
            .word_a      (coef_t'(bank_rd[0][l])),
            .word_b      (coef_t'(bank_rd[1][l])),
            .rd_vld      (lane_rd_vld[l]),
            .rd_word     (lane_word[l]),
            .seg_bank    (lane_bank[l])
        );

        assign lane_rd_re[l*PART_W +: PART_W] = lane_word[l].re;
        assign lane_rd_im[l*PART_W +: PART_W] = lane_word[l].im;
        assign lane_rd_tag[l]                 = lane_word[l].tag;
    end

    // R8
    no_write_held_chk: assert property (@(posedge clk) disable iff (rst)
        held |-> !ld_we);

    // R3
    no_write_full_chk: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> !ld_we);

endmodule

// File: tb/test_coef_pingpong_buf.sv
module test_coef_pingpong_buf;

    localparam int L  = 32;
    localparam int NL = 2;
    localparam int AW = 5;

    logic              clk = 1'b0;
    logic              rst;
    logic              host_valid;
    logic [31:0]       host_word;
    logic              host_tag;
    logic              refresh;
    logic              active_valid;
    logic              underrun;
    logic [NL-1:0]     lane_rd_en;
    logic [NL*AW-1:0]  lane_rd_addr;
    logic [NL-1:0]     lane_rd_vld;
    logic [NL*16-1:0]  lane_rd_re;
    logic [NL*16-1:0]  lane_rd_im;
    logic [NL-1:0]     lane_rd_tag;

    always #4 clk = ~clk;

    coef_pingpong_buf #(.PROF_LEN(L), .NUM_LANES(NL)) i_coef_pingpong_buf (
        .clk          (clk),
        .rst          (rst),
        .host_valid   (host_valid),
        .host_word    (host_word),
        .host_tag     (host_tag),
        .refresh      (refresh),
        .active_valid (active_valid),
        .underrun     (underrun),
        .lane_rd_en   (lane_rd_en),
        .lane_rd_addr (lane_rd_addr),
        .lane_rd_vld  (lane_rd_vld),
        .lane_rd_re   (lane_rd_re),
        .lane_rd_im   (lane_rd_im),
        .lane_rd_tag  (lane_rd_tag)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R2";

    // behavioural reference state
    logic [32:0] m_mem   [2][L];
    bit          m_known [2][L];
    int          m_act, m_fill, m_lb[NL];
    bit          m_full, m_ftag, m_und, m_aval;
    logic [32:0] e_data  [NL];
    bit          e_known [NL];
    bit          e_vld   [NL];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int addr_of(input int l);
        return int'(lane_rd_addr[l*AW +: AW]);
    endfunction

    task automatic model_step();
        int  wb = 1 - m_act;
        bit  held = 0;
        bit  swp = refresh && m_full;
        for (int l = 0; l < NL; l++) if (m_lb[l] == wb) held = 1;
        for (int l = 0; l < NL; l++) begin
            int a = addr_of(l);
            int sel = (lane_rd_en[l] && a == 0) ? m_act : m_lb[l];
            e_vld[l] = lane_rd_en[l];
            if (lane_rd_en[l]) begin
                e_data[l]  = m_mem[sel][a];
                e_known[l] = m_known[sel][a];
                if (a == 0) m_lb[l] = m_act;
            end
        end
        if (host_valid && !m_full && !held) begin
            int wa = (m_fill > 0 && host_tag != m_ftag) ? 0 : m_fill;
            m_mem[wb][wa]   = {host_tag, host_word};
            m_known[wb][wa] = 1;
            if (wa == 0) m_ftag = host_tag;
            m_fill = wa + 1;
            m_full = (m_fill == L);
        end
        if (swp) begin
            m_act = wb; m_fill = 0; m_full = 0; m_aval = 1; m_und = 0;
        end else if (refresh) begin
            m_und = 1;
        end
    endtask

    task automatic compare();
        chk(active_valid == m_aval, "R5", "active_valid", 64'(active_valid), 64'(m_aval));
        chk(underrun == m_und, "R6", "underrun", 64'(underrun), 64'(m_und));
        for (int l = 0; l < NL; l++) begin
            chk(lane_rd_vld[l] == e_vld[l], "R2", "lane_rd_vld",
                64'(lane_rd_vld[l]), 64'(e_vld[l]));
            if (e_known[l]) begin
                logic [32:0] got = {lane_rd_tag[l], lane_rd_re[l*16 +: 16], lane_rd_im[l*16 +: 16]};
                chk(got == e_data[l], cur_req, "lane word", 64'(got), 64'(e_data[l]));
            end
        end
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        host_valid = 0; refresh = 0; lane_rd_en = '0;
    endtask

    task automatic put(input logic [31:0] w, input logic t);
        host_valid = 1; host_word = w; host_tag = t;
        cyc();
    endtask

    task automatic set_rd(input int l, input int a);
        lane_rd_en[l] = 1;
        lane_rd_addr[l*AW +: AW] = AW'(a);
    endtask

    task automatic strobe();
        refresh = 1;
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        int          seg[NL];
        bit          rtag;
        rst = 1; host_valid = 0; host_word = '0; host_tag = 0; refresh = 0;
        lane_rd_en = '0; lane_rd_addr = '0;
        m_act = 0; m_fill = 0; m_full = 0; m_ftag = 0; m_und = 0; m_aval = 0;
        for (int l = 0; l < NL; l++) begin m_lb[l] = 0; e_vld[l] = 0; e_known[l] = 0; e_data[l] = '0; end
        for (int b = 0; b < 2; b++) for (int i = 0; i < L; i++) begin m_known[b][i] = 0; m_mem[b][i] = '0; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(active_valid == 0, "R1", "active_valid", 64'(active_valid), 0);
        chk(underrun == 0, "R1", "underrun", 64'(underrun), 0);
        chk(lane_rd_vld == '0, "R1", "lane_rd_vld", 64'(lane_rd_vld), 0);

        // R6: strobe on an empty fill bank
        cur_req = "R6";
        strobe();
        chk(underrun == 1, "R6", "underrun after empty strobe", 64'(underrun), 1);

        // R4: partial fill with tag 1, then restart with tag 0
        cur_req = "R4";
        for (int i = 0; i < 5; i++) put(32'h1000 + i, 1'b1);
        for (int i = 0; i < L; i++) put(32'hA000_0000 + i * 32'h0001_0003, 1'b0);
        // R3: word after completion is ignored
        cur_req = "R3";
        put(32'hDEAD_BEEF, 1'b0);

        // R5: exchange
        cur_req = "R5";
        strobe();
        chk(active_valid == 1 && underrun == 0, "R5", "valid/underrun after swap",
            64'({active_valid, underrun}), 64'(2'b10));

        // R8: writes while lanes still bound to the fill bank are ignored
        cur_req = "R8";
        for (int i = 0; i < 4; i++) put(32'h5555_0000 + i, 1'b1);

        // R9: lanes start segments and read in opposite orders
        cur_req = "R9";
        set_rd(0, 0); set_rd(1, 0); cyc();
        for (int i = 0; i < L; i++) begin set_rd(0, i); set_rd(1, L - 1 - i); cyc(); end

        // R8: load the released bank with tag 1
        cur_req = "R8";
        for (int i = 0; i < L; i++) put(32'h0F00_7000 ^ (i * 32'h0101_0011), 1'b1);

        // R7: exchange in the middle of lane 0's segment
        cur_req = "R7";
        for (int i = 0; i < 10; i++) begin set_rd(0, i); cyc(); end
        set_rd(0, 10); refresh = 1; cyc();
        for (int i = 11; i < L; i++) begin set_rd(0, i); cyc(); end
        for (int i = 0; i < L; i++) begin set_rd(0, i); cyc(); end

        // R10: partial fill does not allow an exchange
        cur_req = "R10";
        set_rd(1, 0); cyc();
        for (int i = 0; i < 20; i++) put(32'h3C3C_0000 + i, 1'b0);
        strobe();
        chk(underrun == 1, "R10", "underrun on partial bank", 64'(underrun), 1);
        for (int i = 20; i < L; i++) put(32'h3C3C_0000 + i, 1'b0);
        strobe();
        chk(underrun == 0, "R10", "underrun after completed fill", 64'(underrun), 0);
        for (int i = 0; i < L; i++) begin set_rd(0, i); set_rd(1, (i * 7) % L); cyc(); end

        // mixed pseudo-random traffic
        cur_req = "R2";
        lfsr = 32'hACE1_1234; rtag = 0;
        for (int l = 0; l < NL; l++) seg[l] = 0;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[15:11] == 0) rtag = ~rtag;
            host_valid = lfsr[0] | lfsr[1];
            host_word  = lfsr ^ 32'h1357_9BDF;
            host_tag   = (lfsr[27:24] == 0) ? ~rtag : rtag;
            refresh    = (lfsr[10:4] == 0);
            for (int l = 0; l < NL; l++) begin
                if (lfsr[20 + l] | lfsr[22 + l]) begin
                    set_rd(l, seg[l]);
                    seg[l] = (seg[l] + 1) % L;
                end
            end
            cyc();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule